// File: doc/BRIEF.md
# Relocatable RAM and Register Window Decoder

This block decodes a 16-bit bus address into one of two internal windows: a 256-byte RAM window and a 64-byte register window. Each window starts on a 4 KB boundary. The top hex digit of each base comes from a one-byte mapping register. On every valid access the decoder gives a select and a local offset. Both are combinational in the address and the valid strobe.

The mapping register sits inside the register window. Software can rewrite it only during a short period after reset, so boot code can move RAM, the registers, or both with a single store. Once a fixed number of valid bus cycles have gone by, the mapping is frozen until the next reset. Where the two windows overlap, the register window takes the access.

Top module: `remap_decoder`

## Requirements
- R1: After reset the mapping register holds 0x01, so RAM decodes at 0x0000–0x00FF with `ram_sel` high and `ram_off` equal to address bits 7:0.
- R2: After reset the register window decodes at 0x1000–0x103F with `reg_sel` high and `reg_off` equal to address bits 5:0.
- R3: A valid write to register offset 0x3D loads the mapping register from `bus_wdata`. Bits 7:4 become the top address nibble of the RAM base and bits 3:0 become the top nibble of the register base, so one write can move both windows. A write to any other register offset leaves the mapping unchanged.
- R4: A mapping write is accepted if it falls within the first 64 valid bus cycles after reset, and this includes the 64th valid cycle itself.
- R5: Once 64 valid cycles have elapsed, mapping writes are ignored until the next reset.
- R6: When both windows contain an address, `reg_sel` is high and `ram_sel` is low.
- R7: Neither select is asserted when `bus_valid` is low.
- R8: An address outside both windows asserts neither select. Examples are 0x0100, 0x1040, 0x0A55 and 0xF000 under the reset mapping.
- R9: Cycles with `bus_valid` low do not advance the write-window count, and a write presented while `bus_valid` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus cycle strobe |
| bus_write | input | 1 | Write qualifier for the current cycle |
| bus_addr | input | 16 | Access address |
| bus_wdata | input | 8 | Write data |
| ram_sel | output | 1 | RAM window selected |
| ram_off | output | 8 | Offset within the RAM window |
| reg_sel | output | 1 | Register window selected |
| reg_off | output | 6 | Offset within the register window |

## Verification
A vector table runs under the reset mapping. It covers both edges of each window, addresses just past each window, addresses that match the base nibble but have stray middle bits, and strobe-low cycles. This separates nibble matching from full-range matching.

Directed sequences then move the windows apart and then onto the same nibble, which exposes the overlap priority. A write to a neighbouring register offset shows that only offset 0x3D loads the mapping register.

A second reset phase runs a long stretch of strobe-low cycles before counting valid cycles. It then places one mapping write on the 64th valid cycle and another on the 65th. This pins the window length exactly and shows that idle cycles are not counted.

// File: rtl/remap_decoder.sv
module remap_decoder #(
  parameter int ADDR_W     = 16,
  parameter int RAM_AW     = 8,
  parameter int REG_AW     = 6,
  parameter int WIN_CYCLES = 64,
  parameter logic [REG_AW-1:0] MAP_OFF = 6'h3D,
  parameter logic [7:0]        MAP_RST = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic              ram_sel,
  output logic [RAM_AW-1:0] ram_off,
  output logic              reg_sel,
  output logic [REG_AW-1:0] reg_off
);
  localparam int CW = $clog2(WIN_CYCLES + 1);

  logic [7:0]    map_q;
  logic [CW-1:0] win_cnt;
  logic          win_open, ram_hit, reg_hit, map_wr;
  logic [3:0]    top_nib;

  assign top_nib  = bus_addr[ADDR_W-1 -: 4];
  assign ram_hit  = (top_nib == map_q[7:4]) && (bus_addr[ADDR_W-5:RAM_AW] == '0);
  assign reg_hit  = (top_nib == map_q[3:0]) && (bus_addr[ADDR_W-5:REG_AW] == '0);

  assign reg_sel  = bus_valid && reg_hit;
  assign ram_sel  = bus_valid && ram_hit && !reg_hit;
  assign ram_off  = bus_addr[RAM_AW-1:0];
  assign reg_off  = bus_addr[REG_AW-1:0];

  assign win_open = (win_cnt < CW'(WIN_CYCLES));
  assign map_wr   = reg_sel && bus_write && win_open && (reg_off == MAP_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      map_q   <= MAP_RST;
    end else begin
      if (bus_valid && win_open) win_cnt <= win_cnt + 1'b1;
      if (map_wr)                map_q   <= bus_wdata;
    end
  end
endmodule

// File: rtl/remap_decoder_chk.sv
module remap_decoder_chk #(
  parameter int ADDR_W     = 16,
  parameter int RAM_AW     = 8,
  parameter int REG_AW     = 6,
  parameter int WIN_CYCLES = 64,
  parameter logic [7:0] MAP_RST = 8'h01
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              ram_sel,
  input logic [RAM_AW-1:0] ram_off,
  input logic              reg_sel,
  input logic [REG_AW-1:0] reg_off,
  input logic [7:0]        map_q
);
  localparam int CW = $clog2(WIN_CYCLES + 1);
  logic [CW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (bus_valid && seen < CW'(WIN_CYCLES)) seen <= seen + 1'b1;
  end

  p_reset_map_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == '0) |-> (map_q == MAP_RST));
  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == CW'(WIN_CYCLES)) |=> $stable(map_q));
  p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_sel && reg_sel));
  p_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_sel || reg_sel) |-> bus_valid);
  p_ram_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel |-> (ram_off == bus_addr[RAM_AW-1:0]));
  p_reg_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> (reg_off == bus_addr[REG_AW-1:0]));
endmodule

bind remap_decoder remap_decoder_chk #(
  .ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .REG_AW(REG_AW),
  .WIN_CYCLES(WIN_CYCLES), .MAP_RST(MAP_RST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
  .ram_sel(ram_sel), .ram_off(ram_off), .reg_sel(reg_sel),
  .reg_off(reg_off), .map_q(map_q)
);

// File: tb/tb_remap_decoder.sv
module tb_remap_decoder;
  logic        clk = 0, rst_n = 0;
  logic        bus_valid = 0, bus_write = 0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        ram_sel, reg_sel;
  logic [7:0]  ram_off;
  logic [5:0]  reg_off;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  remap_decoder dut (.*);

  // {addr, valid, exp_ram, exp_reg, exp_off}
  localparam int NV = 12;
  localparam logic [26:0] VEC [NV] = '{
    {16'h0000, 1'b1, 1'b1, 1'b0, 8'h00},
    {16'h00FF, 1'b1, 1'b1, 1'b0, 8'hFF},
    {16'h0042, 1'b1, 1'b1, 1'b0, 8'h42},
    {16'h0100, 1'b1, 1'b0, 1'b0, 8'h00},
    {16'h1000, 1'b1, 1'b0, 1'b1, 8'h00},
    {16'h103F, 1'b1, 1'b0, 1'b1, 8'h3F},
    {16'h1040, 1'b1, 1'b0, 1'b0, 8'h00},
    {16'h0080, 1'b0, 1'b0, 1'b0, 8'h00},
    {16'h1010, 1'b0, 1'b0, 1'b0, 8'h00},
    {16'hF000, 1'b1, 1'b0, 1'b0, 8'h00},
    {16'h0A55, 1'b1, 1'b0, 1'b0, 8'h00},
    {16'h1E3F, 1'b1, 1'b0, 1'b0, 8'h00}
  };

  task automatic drive(input logic [15:0] a, input logic v, input logic w, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_valid = v; bus_write = w; bus_wdata = d;
    #2;
  endtask

  task automatic expect_dec(input string tag, input logic er, input logic eg, input logic [7:0] eo);
    logic [7:0] act_off;
    act_off = ram_sel ? ram_off : (reg_sel ? {2'b00, reg_off} : 8'h00);
    checks++;
    if (ram_sel !== er || reg_sel !== eg || act_off !== eo) begin
      fails++;
      $display("FAIL %s addr=%h: actual ram=%b reg=%b off=%h expected ram=%b reg=%b off=%h",
               tag, bus_addr, ram_sel, reg_sel, act_off, er, eg, eo);
    end
  endtask

  task automatic probe(input string tag, input logic [15:0] a, input logic er, input logic eg, input logic [7:0] eo);
    drive(a, 1'b1, 1'b0, 8'h00);
    expect_dec(tag, er, eg, eo);
  endtask

  task automatic do_reset();
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 R2 R7 R8: table walk under reset mapping
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][26:11], VEC[i][10], 1'b0, 8'h00);
      expect_dec("R1/R2/R7/R8 table", VEC[i][9], VEC[i][8], VEC[i][7:0]);
    end
    // R3: neighbouring offset does not touch mapping
    drive(16'h103C, 1'b1, 1'b1, 8'h77);
    probe("R3 other offset", 16'h1000, 1'b0, 1'b1, 8'h00);
    probe("R3 other offset", 16'h0010, 1'b1, 1'b0, 8'h10);
    // R3: move both windows in one write
    drive(16'h103D, 1'b1, 1'b1, 8'h23);
    probe("R3 ram moved", 16'h20FF, 1'b1, 1'b0, 8'hFF);
    probe("R3 reg moved", 16'h3021, 1'b0, 1'b1, 8'h21);
    probe("R3 old ram gone", 16'h0000, 1'b0, 1'b0, 8'h00);
    probe("R3 old reg gone", 16'h1000, 1'b0, 1'b0, 8'h00);
    // R6: overlap
    drive(16'h303D, 1'b1, 1'b1, 8'h33);
    probe("R6 overlap reg wins", 16'h3000, 1'b0, 1'b1, 8'h00);
    probe("R6 overlap reg wins", 16'h303F, 1'b0, 1'b1, 8'h3F);
    probe("R6 ram above regs", 16'h3040, 1'b1, 1'b0, 8'h40);

    // R9 R4 R5: window length
    do_reset();
    for (int i = 0; i < 100; i++) drive(16'h103D, 1'b0, 1'b1, 8'h99);
    expect_dec("R9 invalid write", 1'b0, 1'b0, 8'h00);
    probe("R9 mapping kept", 16'h1000, 1'b0, 1'b1, 8'h00);       // valid #1
    for (int i = 0; i < 62; i++) drive(16'h8000, 1'b1, 1'b0, 8'h00); // #2..#63
    drive(16'h103D, 1'b1, 1'b1, 8'h45);                          // #64 accepted
    drive(16'h503D, 1'b1, 1'b1, 8'h67);                          // #65 ignored
    probe("R4 64th write taken", 16'h5000, 1'b0, 1'b1, 8'h00);
    probe("R4 ram moved", 16'h4080, 1'b1, 1'b0, 8'h80);
    probe("R5 late write ignored", 16'h7000, 1'b0, 1'b0, 8'h00);
    probe("R5 late write ignored", 16'h6000, 1'b0, 1'b0, 8'h00);

    // R1: reset restores default mapping
    do_reset();
    probe("R1 after re-reset", 16'h0001, 1'b1, 1'b0, 8'h01);
    probe("R2 after re-reset", 16'h103D, 1'b0, 1'b1, 8'h3D);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule